// File: doc/BRIEF.md
# UART Status and Interrupt Flags

This block keeps the status word of a simple UART and produces its single interrupt request. The transmit and receive datapaths do not appear here. They report to the block through one-cycle event strobes: the holding register moved into the shift register, the shift register drained, a byte received, a break detected, and a framing, parity or overrun error. Software reaches the block through a small register bus. Each access on that bus completes in the cycle it is presented. The bus has no back-pressure and no ready signal, and read data is valid in the same cycle as the request.

The two transmit flags follow a hidden holding/shift occupancy model. Writing the data register fills the holding register and clears both flags. A transfer strobe empties the holding register and occupies the shift register. A shift-done strobe frees the shift register. The receive-ready flag sets on a receive strobe and is cleared by a bus read of the data register. The four error flags are sticky and are cleared only by writing ones to them. Each flag has its own enable bit. A registered OR of the enabled flags drives the interrupt line.

Top module: `uart_sif_top`

## Requirements
- R1: After reset the status word reads 0x0000_0180, the enable register reads 0 and `irq` is 0.
- R2: Status bit 7 (transmit empty) clears on a data-register write and sets on a transfer strobe. When a write and a transfer land in the same cycle, the bit ends that cycle at 0.
- R3: Status bit 8 (transmit complete) is 1 only while the holding register is empty and the shift register is idle. A shift-done strobe with the holding register empty sets it. A data-register write clears it.
- R4: Bits 8 and 7 are read-only: writing ones to them at the status offset changes neither bit.
- R5: Status bit 5 (receive ready) sets on a receive strobe and clears on a bus read of the data register. If both happen in one cycle, the set wins. Write-one-to-clear at the status offset does not affect it.
- R6: The error flags sit at bit 4 (break), bit 3 (framing), bit 2 (parity) and bit 0 (overrun). Each sets on its strobe and stays set until cleared.
- R7: At the status offset, a 1 written to an error-flag bit clears that flag and a 0 leaves it unchanged. A strobe in the same cycle as a clear leaves the flag set.
- R8: Status bits 31:9, 6 and 1 always read 0.
- R9: The enable register at offset 0x04 holds bit 0 receive ready, bit 1 transmit empty, bit 2 transmit complete, bit 3 break, bit 4 framing, bit 5 parity and bit 6 overrun. Its other bits read 0.
- R10: `irq` is the OR over all flags of each flag ANDed with its enable. It is registered, so it reflects the flags and enables of the previous cycle.
- R11: The data register is at offset 0x00 and the status register at offset 0x10. A bus cycle is a write when `bus_write` is 1 and a read otherwise. A read of the data register returns 0 from this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_load | input | 1 | Holding register moved into the shift register |
| ev_tx_shift_empty | input | 1 | Shift register finished and is idle |
| ev_rx_data | input | 1 | Received byte available |
| ev_rx_break | input | 1 | Break condition detected |
| ev_rx_frame_err | input | 1 | Framing error detected |
| ev_rx_parity_err | input | 1 | Parity error detected |
| ev_rx_overrun | input | 1 | Receive overrun detected |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle: transmit complete never stands without transmit empty, a data write always drops transmit empty, and transfer, receive and overrun strobes always leave their flags set a cycle later. They also check that uncleared error flags persist, that the transmit bits survive clear writes, that reserved bits stay 0, and that `irq` equals the enabled-flag OR of the prior cycle. Only the bench scenarios can show the exact status values after ordered sequences. These include a write colliding with a transfer, receive-ready losing to a fresh strobe, and a zero write leaving flags alone. The bench also covers the enable register's width masking and the interrupt rising and falling with enable changes.

// File: rtl/uart_sif_pkg.sv
package uart_sif_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned NUM_STICKY = 5;

  localparam int unsigned OFS_DATA = 32'h00;
  localparam int unsigned OFS_IEN  = 32'h04;
  localparam int unsigned OFS_STAT = 32'h10;

  localparam int unsigned BIT_OVR = 0;
  localparam int unsigned BIT_PAR = 2;
  localparam int unsigned BIT_FRM = 3;
  localparam int unsigned BIT_BRK = 4;
  localparam int unsigned BIT_RXR = 5;
  localparam int unsigned BIT_TXE = 7;
  localparam int unsigned BIT_TXC = 8;

  typedef enum int unsigned {
    SRC_RXR = 0, SRC_TXE = 1, SRC_TXC = 2, SRC_BRK = 3,
    SRC_FRM = 4, SRC_PAR = 5, SRC_OVR = 6
  } src_idx_e;

  typedef enum int unsigned {
    STK_OVR = 0, STK_PAR = 1, STK_FRM = 2, STK_BRK = 3, STK_RXR = 4
  } stk_idx_e;
endpackage

// File: rtl/uart_sif_txtrack.sv
module uart_sif_txtrack (
  input  logic clk,
  input  logic rst_n,
  input  logic data_wr,
  input  logic xfer,
  input  logic shift_done,
  output logic tx_empty,
  output logic tx_complete
);
  logic hold_full_q;
  logic shift_busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full_q  <= 1'b0;
      shift_busy_q <= 1'b0;
    end else begin
      // a new write refills the holding register even if a transfer drains it
      if (data_wr)   hold_full_q <= 1'b1;
      else if (xfer) hold_full_q <= 1'b0;
      if (xfer)            shift_busy_q <= 1'b1;
      else if (shift_done) shift_busy_q <= 1'b0;
    end
  end

  assign tx_empty    = !hold_full_q;
  assign tx_complete = !hold_full_q && !shift_busy_q;
endmodule

// File: rtl/uart_sif_flags.sv
module uart_sif_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      f_q <= 1'b0;
      else if (set[i]) f_q <= 1'b1;   // set has priority over clear
      else if (clr[i]) f_q <= 1'b0;
    end
    assign q[i] = f_q;
  end
endmodule

// File: rtl/uart_sif_irq.sv
module uart_sif_irq #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  logic pend;
  assign pend = |(flags & enables);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend;
  end
endmodule

// File: rtl/uart_sif_top.sv
module uart_sif_top
  import uart_sif_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_load,
  input  logic              ev_tx_shift_empty,
  input  logic              ev_rx_data,
  input  logic              ev_rx_break,
  input  logic              ev_rx_frame_err,
  input  logic              ev_rx_parity_err,
  input  logic              ev_rx_overrun,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic hit_data, hit_ien, hit_stat;
  logic wr_data, rd_data, wr_ien, wr_stat;

  assign hit_data = bus_valid && (bus_addr == A_DATA);
  assign hit_ien  = bus_valid && (bus_addr == A_IEN);
  assign hit_stat = bus_valid && (bus_addr == A_STAT);
  assign wr_data  = hit_data &&  bus_write;
  assign rd_data  = hit_data && !bus_write;
  assign wr_ien   = hit_ien  &&  bus_write;
  assign wr_stat  = hit_stat &&  bus_write;

  // transmit occupancy
  logic tx_empty, tx_complete;
  uart_sif_txtrack u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_wr     (wr_data),
    .xfer        (ev_tx_load),
    .shift_done  (ev_tx_shift_empty),
    .tx_empty    (tx_empty),
    .tx_complete (tx_complete)
  );

  // sticky receive-side flags
  logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_q;
  always_comb begin
    stk_set = '0;
    stk_clr = '0;
    stk_set[STK_OVR] = ev_rx_overrun;
    stk_set[STK_PAR] = ev_rx_parity_err;
    stk_set[STK_FRM] = ev_rx_frame_err;
    stk_set[STK_BRK] = ev_rx_break;
    stk_set[STK_RXR] = ev_rx_data;
    stk_clr[STK_OVR] = wr_stat && bus_wdata[BIT_OVR];
    stk_clr[STK_PAR] = wr_stat && bus_wdata[BIT_PAR];
    stk_clr[STK_FRM] = wr_stat && bus_wdata[BIT_FRM];
    stk_clr[STK_BRK] = wr_stat && bus_wdata[BIT_BRK];
    stk_clr[STK_RXR] = rd_data;
  end

  uart_sif_flags #(.N(NUM_STICKY)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (stk_set),
    .clr   (stk_clr),
    .q     (stk_q)
  );

  // interrupt enables
  logic [NUM_SRC-1:0] ien_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[NUM_SRC-1:0];
  end

  // status word assembly
  logic [REG_W-1:0] status_w;
  always_comb begin
    status_w          = '0;
    status_w[BIT_OVR] = stk_q[STK_OVR];
    status_w[BIT_PAR] = stk_q[STK_PAR];
    status_w[BIT_FRM] = stk_q[STK_FRM];
    status_w[BIT_BRK] = stk_q[STK_BRK];
    status_w[BIT_RXR] = stk_q[STK_RXR];
    status_w[BIT_TXE] = tx_empty;
    status_w[BIT_TXC] = tx_complete;
  end

  // interrupt sources in enable-bit order
  logic [NUM_SRC-1:0] src_vec;
  always_comb begin
    src_vec          = '0;
    src_vec[SRC_RXR] = stk_q[STK_RXR];
    src_vec[SRC_TXE] = tx_empty;
    src_vec[SRC_TXC] = tx_complete;
    src_vec[SRC_BRK] = stk_q[STK_BRK];
    src_vec[SRC_FRM] = stk_q[STK_FRM];
    src_vec[SRC_PAR] = stk_q[STK_PAR];
    src_vec[SRC_OVR] = stk_q[STK_OVR];
  end

  uart_sif_irq #(.N(NUM_SRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (src_vec),
    .enables (ien_q),
    .irq     (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ien && !bus_write)       bus_rdata = REG_W'(ien_q);
    else if (hit_stat && !bus_write) bus_rdata = status_w;
  end
endmodule

// File: rtl/uart_sif_chk.sv
module uart_sif_chk
  import uart_sif_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [REG_W-1:0]   bus_wdata,
  input logic               ev_tx_load,
  input logic               ev_tx_shift_empty,
  input logic               ev_rx_data,
  input logic               ev_rx_overrun,
  input logic [REG_W-1:0]   status,
  input logic [NUM_SRC-1:0] ien,
  input logic               irq
);
  localparam logic [REG_W-1:0] ERR_MASK = REG_W'(32'h1D);
  localparam logic [REG_W-1:0] RSV_MASK = ~REG_W'(32'h1BD);

  logic wr_d, w1c;
  logic [REG_W-1:0] keep;
  logic pend;

  assign wr_d = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_DATA));
  assign w1c  = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_STAT));
  assign keep = status & ERR_MASK & ~(w1c ? bus_wdata : '0);
  assign pend = (status[BIT_RXR] & ien[0]) | (status[BIT_TXE] & ien[1]) |
                (status[BIT_TXC] & ien[2]) | (status[BIT_BRK] & ien[3]) |
                (status[BIT_FRM] & ien[4]) | (status[BIT_PAR] & ien[5]) |
                (status[BIT_OVR] & ien[6]);

  a_r2_write_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_d |=> !status[BIT_TXE]);
  a_r2_load_sets_txe: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_load && !wr_d) |=> status[BIT_TXE]);
  a_r3_txc_needs_txe: assert property (@(posedge clk) disable iff (!rst_n)
    status[BIT_TXC] |-> status[BIT_TXE]);
  a_r4_tx_bits_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !ev_tx_load && !ev_tx_shift_empty) |=> status[8:7] == $past(status[8:7]));
  a_r5_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_data |=> status[BIT_RXR]);
  a_r6_errors_persist: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(keep)) == $past(keep)));
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |=> status[BIT_OVR]);
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & RSV_MASK) == '0);
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(pend));
endmodule

bind uart_sif_top uart_sif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .bus_valid         (bus_valid),
  .bus_write         (bus_write),
  .bus_addr          (bus_addr),
  .bus_wdata         (bus_wdata),
  .ev_tx_load        (ev_tx_load),
  .ev_tx_shift_empty (ev_tx_shift_empty),
  .ev_rx_data        (ev_rx_data),
  .ev_rx_overrun     (ev_rx_overrun),
  .status            (status_w),
  .ien               (ien_q),
  .irq               (irq)
);

// File: tb/tb_uart_sif_top.sv
module tb_uart_sif_top;
  localparam int AW = 8;
  localparam logic [2:0] OP_NOP = 3'd0, OP_WD = 3'd1, OP_RD = 3'd2,
                         OP_W1C = 3'd3, OP_WEN = 3'd4;
  // {req[3:0], events{load,idle,rx,brk,fe,pe,ov}[6:0], op[2:0], wdata[15:0], expected status[15:0]}
  localparam int NV = 17;
  localparam logic [45:0] VEC [NV] = '{
    {4'd1,  7'b0000000, OP_NOP, 16'h0000, 16'h0180}, // R1 idle after reset
    {4'd2,  7'b0000000, OP_WD,  16'h0055, 16'h0000}, // R2 R3 write clears both
    {4'd2,  7'b1000000, OP_NOP, 16'h0000, 16'h0080}, // R2 transfer sets txe
    {4'd2,  7'b1000000, OP_WD,  16'h0000, 16'h0000}, // R2 write+transfer -> 0
    {4'd2,  7'b1000000, OP_NOP, 16'h0000, 16'h0080}, // R2
    {4'd3,  7'b0100000, OP_NOP, 16'h0000, 16'h0180}, // R3 shift done
    {4'd5,  7'b0010000, OP_NOP, 16'h0000, 16'h01A0}, // R5 rx set
    {4'd5,  7'b0000000, OP_RD,  16'h0000, 16'h0180}, // R5 data read clears
    {4'd5,  7'b0010000, OP_RD,  16'h0000, 16'h01A0}, // R5 set wins
    {4'd6,  7'b0001100, OP_NOP, 16'h0000, 16'h01B8}, // R6 break+frame
    {4'd7,  7'b0000000, OP_W1C, 16'h0008, 16'h01B0}, // R7 clear frame
    {4'd7,  7'b0000000, OP_W1C, 16'h0000, 16'h01B0}, // R7 zero keeps
    {4'd7,  7'b0000011, OP_W1C, 16'h0005, 16'h01B5}, // R7 set beats clear
    {4'd4,  7'b0000000, OP_W1C, 16'h01A0, 16'h01B5}, // R4 R5 read-only bits
    {4'd7,  7'b0000000, OP_W1C, 16'hFFFF, 16'h01A0}, // R7 R8 clear all errors
    {4'd11, 7'b0000000, OP_RD,  16'h0000, 16'h0180}, // R11 data offset read
    {4'd3,  7'b0100000, OP_NOP, 16'h0000, 16'h0180}  // R3 idle when already done
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_tx_load, ev_tx_shift_empty, ev_rx_data, ev_rx_break;
  logic ev_rx_frame_err, ev_rx_parity_err, ev_rx_overrun;
  logic bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  uart_sif_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_tx_load(ev_tx_load),
    .ev_tx_shift_empty(ev_tx_shift_empty), .ev_rx_data(ev_rx_data),
    .ev_rx_break(ev_rx_break), .ev_rx_frame_err(ev_rx_frame_err),
    .ev_rx_parity_err(ev_rx_parity_err), .ev_rx_overrun(ev_rx_overrun),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] a);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
    #1;
  endtask

  // called at a negedge; returns at the next negedge with events cleared
  task automatic step(input logic [6:0] ev, input logic [2:0] op, input logic [31:0] wd);
    {ev_tx_load, ev_tx_shift_empty, ev_rx_data, ev_rx_break,
     ev_rx_frame_err, ev_rx_parity_err, ev_rx_overrun} = ev;
    bus_valid = (op != OP_NOP); bus_wdata = wd;
    bus_write = (op == OP_WD) || (op == OP_W1C) || (op == OP_WEN);
    case (op)
      OP_WD, OP_RD: bus_addr = AW'(8'h00);
      OP_WEN:       bus_addr = AW'(8'h04);
      default:      bus_addr = AW'(8'h10);
    endcase
    @(negedge clk);
    {ev_tx_load, ev_tx_shift_empty, ev_rx_data, ev_rx_break,
     ev_rx_frame_err, ev_rx_parity_err, ev_rx_overrun} = '0;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step('0, OP_NOP, '0);
    step('0, OP_NOP, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ev_tx_load = 0; ev_tx_shift_empty = 0; ev_rx_data = 0; ev_rx_break = 0;
    ev_rx_frame_err = 0; ev_rx_parity_err = 0; ev_rx_overrun = 0;
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    do_reset();

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][41:35], VEC[i][34:32], {16'h0, VEC[i][31:16]});
      look(AW'(8'h10));
      check($sformatf("R%0d vec%0d", VEC[i][45:42], i), bus_rdata, {16'h0, VEC[i][15:0]});
      @(negedge clk);
    end

    // R1 reset state
    do_reset();
    look(AW'(8'h10)); check("R1 status", bus_rdata, 32'h180);
    look(AW'(8'h04)); check("R1 enable", bus_rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R9 enable masking, R10 one-cycle latency
    step('0, OP_WEN, 32'hFFFF_FFFF);
    look(AW'(8'h04)); check("R9 enable width", bus_rdata, 32'h7F);
    check("R10 irq not yet", {31'b0, irq}, 32'h0);
    step('0, OP_NOP, '0);
    check("R10 irq rises", {31'b0, irq}, 32'h1);

    step('0, OP_WEN, 32'h40);
    check("R10 irq holds one cycle", {31'b0, irq}, 32'h1);
    step('0, OP_NOP, '0);
    check("R10 irq falls", {31'b0, irq}, 32'h0);

    step(7'b0000001, OP_NOP, '0);
    look(AW'(8'h10)); check("R6 overrun set", bus_rdata, 32'h181);
    check("R10 irq lag", {31'b0, irq}, 32'h0);
    step('0, OP_NOP, '0);
    check("R10 overrun irq", {31'b0, irq}, 32'h1);
    step('0, OP_W1C, 32'h1);
    check("R10 irq after clear lag", {31'b0, irq}, 32'h1);
    step('0, OP_NOP, '0);
    check("R7 R10 irq cleared", {31'b0, irq}, 32'h0);
    look(AW'(8'h10)); check("R7 overrun cleared", bus_rdata, 32'h180);
    look(AW'(8'h00)); check("R11 data read zero", bus_rdata, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule